// File: doc/BRIEF.md
# Calendar Time Keeper with Posted Writes

This block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day, month, year) that advance on a one-cycle tick input, normally pulsed once per second. Software sees the time and the date as two packed words, plus an alarm-time word and a control word that carries three busy flags, over a simple single-cycle register bus. Read data comes back registered, one cycle after the address is presented.

Writes to the time, date and alarm words are posted. The written value is held in a staging register and the matching busy flag is raised; the value reaches the live counters a fixed number of cycles later, at which point the flag drops. Software is expected to poll the flags before writing, and a write aimed at a word whose flag is still set is discarded. A software-owned leap bit stored with the date decides whether February has 28 or 29 days; the year is a 6-bit count of years since 1970 that wraps from 63 back to 0.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year 0, leap 0) and the alarm word reads 0.
- R2: Each cycle with tick high (and no write being applied) advances the time by one second: seconds go 59 to 0 and carry into minutes, minutes go 59 to 0 and carry into hours, hours go 23 to 0 and carry into the date.
- R3: On a day carry the date steps to the next day; the last day is 30 for months 4, 6, 9 and 11, 31 for the other months except February, and for February 29 when the leap bit is 1 and 28 otherwise. After the last day the day becomes 1 and the month steps; after month 12 the month becomes 1 and the year increments, wrapping from 63 to 0. The leap bit is never changed by counting.
- R4: Register map (byte offsets): control at 0x00 with busy flags in bits 9 (alarm), 8 (time) and 7 (date); date at 0x10 with day in bits 4:0, month in 11:8, year in 21:16, leap in 22; time at 0x14 with seconds in 5:0, minutes in 13:8, hours in 20:16; alarm at 0x18 with seconds 5:0, minutes 13:8, hours 20:16, day 28:24. Every other bit reads 0, an unmapped offset reads 0, and read data appears one cycle after the address.
- R5: A write to the time, date or alarm word sets its busy flag at the write edge; the value is applied on the third rising edge after the write edge, when the flag also clears. Until then reads return the previous value, and the flag reads 1 in the three reads that follow the write.
- R6: A write to a word whose busy flag is set is ignored; the pending value is the one applied.
- R7: If a tick arrives in the cycle a time or date write is applied, the written value is kept and that tick is dropped for the whole calendar.
- R8: The three posting paths are independent: a time write does not change the date, and time and date writes may be pending together (control reads 0x180).
- R9: Writes to the control word or to an unmapped offset change no state.
- R10: Write-data bits outside the defined fields are discarded and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, advance one second |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
The range assertions on the live counters take for granted that software only writes in-range field values (seconds and minutes below 60, hours below 24, month 1 to 12, day 1 to the month length) and never writes while the matching flag is set except when that is the point of a test; every value the bench writes is built from legal fields, including the write that carries junk in the undefined bits. The assertions on the posting paths assume ticks and writes may coincide freely, and the bench deliberately places ticks on the apply cycle and places a second write inside the busy window. Calendar sweeps cover every month with both leap settings at the last day plus the year wrap, and a long tick run crosses every second and minute value and an hour and day carry, each compared against arithmetic in the bench.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int DATA_W   = 32;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int DAY_W    = 5;
  localparam int MON_W    = 4;
  localparam int YR_W     = 6;

  // posting channel indices; busy flag of channel g sits at BUSY_LSB + g
  localparam int CH_YMD   = 0;
  localparam int CH_HMS   = 1;
  localparam int CH_ALM   = 2;
  localparam int N_CH     = 3;
  localparam int BUSY_LSB = 7;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_YMD  = 'h10;
  localparam int OFF_HMS  = 'h14;
  localparam int OFF_ALM  = 'h18;

  typedef struct packed {
    logic [HR_W-1:0]  hour;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } hms_t;

  typedef struct packed {
    logic             leap;
    logic [YR_W-1:0]  year;
    logic [MON_W-1:0] month;
    logic [DAY_W-1:0] day;
  } ymd_t;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    hms_t             hms;
  } alm_t;

  localparam hms_t HMS_RST = '{hour: '0, min: '0, sec: '0};
  localparam ymd_t YMD_RST = '{leap: 1'b0, year: '0, month: MON_W'(1), day: DAY_W'(1)};

  function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] month,
                                                   input logic leap);
    case (month)
      MON_W'(2):                                     month_days = leap ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11):   month_days = DAY_W'(30);
      default:                                       month_days = DAY_W'(31);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] hms_word(input hms_t t);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEC_W-1:0]      = t.sec;
    w[8 +: MIN_W]     = t.min;
    w[16 +: HR_W]     = t.hour;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] ymd_word(input ymd_t d);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DAY_W-1:0]      = d.day;
    w[8 +: MON_W]     = d.month;
    w[16 +: YR_W]     = d.year;
    w[22]             = d.leap;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] alm_word(input alm_t a);
    logic [DATA_W-1:0] w;
    w = hms_word(a.hms);
    w[24 +: DAY_W]    = a.day;
    return w;
  endfunction

endpackage

// File: rtl/rtc_post_chan.sv
module rtc_post_chan #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic post,
  output logic busy,
  output logic apply
);

  localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam int AGE_W = $clog2(DELAY + 1) + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (post) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(DELAY - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign apply = busy && (cnt == '0);

  // cycles spent busy, saturating; only used by the window check below
  logic [AGE_W-1:0] age;
  always_ff @(posedge clk) begin
    if (rst || !busy) age <= '0;
    else if (age != '1) age <= age + 1'b1;
  end

  // R5: an idle channel that is posted to is busy on the next cycle
  a_r5_flag_on_post: assert property (@(posedge clk) disable iff (rst)
    (post && !busy) |=> busy);

  // R5: busy never lasts longer than the apply delay
  a_r5_busy_window: assert property (@(posedge clk) disable iff (rst)
    busy |-> (age < AGE_W'(DELAY)));

  // R5: apply happens exactly on the last busy cycle
  a_r5_apply_clears: assert property (@(posedge clk) disable iff (rst)
    apply |=> !busy);

  // R6: a post into a busy channel does not restart it
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (post && busy && apply) |=> !busy);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load_hms,
  input  hms_t hms_in,
  input  logic load_ymd,
  input  ymd_t ymd_in,
  output hms_t hms_q,
  output ymd_t ymd_q
);

  hms_t             hms_nx;
  ymd_t             ymd_nx;
  logic [DAY_W-1:0] last_day;

  assign last_day = month_days(ymd_q.month, ymd_q.leap);

  always_comb begin
    hms_nx = hms_q;
    ymd_nx = ymd_q;
    if (hms_q.sec >= SEC_W'(59)) begin
      hms_nx.sec = '0;
      if (hms_q.min >= MIN_W'(59)) begin
        hms_nx.min = '0;
        if (hms_q.hour >= HR_W'(23)) begin
          hms_nx.hour = '0;
          if (ymd_q.day >= last_day) begin
            ymd_nx.day = DAY_W'(1);
            if (ymd_q.month >= MON_W'(12)) begin
              ymd_nx.month = MON_W'(1);
              ymd_nx.year  = ymd_q.year + 1'b1;
            end else begin
              ymd_nx.month = ymd_q.month + 1'b1;
            end
          end else begin
            ymd_nx.day = ymd_q.day + 1'b1;
          end
        end else begin
          hms_nx.hour = hms_q.hour + 1'b1;
        end
      end else begin
        hms_nx.min = hms_q.min + 1'b1;
      end
    end else begin
      hms_nx.sec = hms_q.sec + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hms_q <= HMS_RST;
      ymd_q <= YMD_RST;
    end else if (load_hms || load_ymd) begin
      if (load_hms) hms_q <= hms_in;
      if (load_ymd) ymd_q <= ymd_in;
    end else if (tick) begin
      hms_q <= hms_nx;
      ymd_q <= ymd_nx;
    end
  end

  // R2: time fields stay in range (assumes legal software writes)
  a_r2_time_legal: assert property (@(posedge clk) disable iff (rst)
    (hms_q.sec < SEC_W'(60)) && (hms_q.min < MIN_W'(60)) && (hms_q.hour < HR_W'(24)));

  // R2: a tick with no load always moves the time
  a_r2_tick_moves: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_hms && !load_ymd) |=> (hms_q != $past(hms_q)));

  // R3: date fields stay in range (assumes legal software writes)
  a_r3_date_legal: assert property (@(posedge clk) disable iff (rst)
    (ymd_q.day != '0) && (ymd_q.day <= last_day) &&
    (ymd_q.month != '0) && (ymd_q.month <= MON_W'(12)));

  // R3: counting never alters the leap bit
  a_r3_leap_kept: assert property (@(posedge clk) disable iff (rst)
    !load_ymd |=> (ymd_q.leap == $past(ymd_q.leap)));

  // R7: the written time wins over a same-cycle tick
  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_hms |=> (hms_q == $past(hms_in)));

  // R8: a time load leaves the date alone
  a_r8_date_kept: assert property (@(posedge clk) disable iff (rst)
    (load_hms && !load_ymd) |=> (ymd_q == $past(ymd_q)));

endmodule

// File: rtl/rtc_readmux.sv
module rtc_readmux
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_CH-1:0]   busy,
  input  hms_t              hms,
  input  ymd_t              ymd,
  input  alm_t              alm,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_nx;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BUSY_LSB +: N_CH] = busy;
  end

  always_comb begin
    if (addr == ADDR_W'(OFF_CTRL))     rd_nx = ctrl_word;
    else if (addr == ADDR_W'(OFF_YMD)) rd_nx = ymd_word(ymd);
    else if (addr == ADDR_W'(OFF_HMS)) rd_nx = hms_word(hms);
    else if (addr == ADDR_W'(OFF_ALM)) rd_nx = alm_word(alm);
    else                               rd_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end

  // R4: spare control bits read as zero
  a_r4_ctrl_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(OFF_CTRL)) |=>
      ((rdata[DATA_W-1:BUSY_LSB+N_CH] == '0) && (rdata[BUSY_LSB-1:0] == '0)));

  // R4: time word has nothing outside its fields
  a_r4_hms_spare_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(OFF_HMS)) |=>
      ((rdata[DATA_W-1:21] == '0) && (rdata[15:14] == '0) && (rdata[7:6] == '0)));

endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int APPLY_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  logic [N_CH-1:0] hit;
  logic [N_CH-1:0] post;
  logic [N_CH-1:0] busy;
  logic [N_CH-1:0] apply;
  logic [N_CH-1:0] accept;

  assign hit[CH_YMD] = (bus_addr == ADDR_W'(OFF_YMD));
  assign hit[CH_HMS] = (bus_addr == ADDR_W'(OFF_HMS));
  assign hit[CH_ALM] = (bus_addr == ADDR_W'(OFF_ALM));

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    assign post[g]   = bus_wr && hit[g];
    assign accept[g] = post[g] && !busy[g];
    rtc_post_chan #(.DELAY(APPLY_DELAY)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .post  (post[g]),
      .busy  (busy[g]),
      .apply (apply[g])
    );
  end

  // field extraction from the write word; other bits are dropped
  hms_t w_hms;
  ymd_t w_ymd;
  alm_t w_alm;
  assign w_hms = '{hour: bus_wdata[20:16], min: bus_wdata[13:8], sec: bus_wdata[5:0]};
  assign w_ymd = '{leap: bus_wdata[22], year: bus_wdata[21:16],
                   month: bus_wdata[11:8], day: bus_wdata[4:0]};
  assign w_alm = '{day: bus_wdata[28:24], hms: w_hms};

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:29], bus_wdata[23], bus_wdata[15:14], bus_wdata[7:6]};

  hms_t hms_stage;
  ymd_t ymd_stage;
  alm_t alm_stage;
  alm_t alm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hms_stage <= HMS_RST;
      ymd_stage <= YMD_RST;
      alm_stage <= '0;
      alm_q     <= '0;
    end else begin
      if (accept[CH_HMS]) hms_stage <= w_hms;
      if (accept[CH_YMD]) ymd_stage <= w_ymd;
      if (accept[CH_ALM]) alm_stage <= w_alm;
      if (apply[CH_ALM])  alm_q     <= alm_stage;
    end
  end

  hms_t hms_q;
  ymd_t ymd_q;

  rtc_calendar u_cal (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load_hms (apply[CH_HMS]),
    .hms_in   (hms_stage),
    .load_ymd (apply[CH_YMD]),
    .ymd_in   (ymd_stage),
    .hms_q    (hms_q),
    .ymd_q    (ymd_q)
  );

  rtc_readmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .busy  (busy),
    .hms   (hms_q),
    .ymd   (ymd_q),
    .alm   (alm_q),
    .rdata (bus_rdata)
  );

  // R6: a time write into a busy path leaves the staged value alone
  a_r6_stage_held: assert property (@(posedge clk) disable iff (rst)
    (post[CH_HMS] && busy[CH_HMS]) |=> (hms_stage == $past(hms_stage)));

  // R9: a write to an unmapped or control offset starts no posting
  a_r9_no_stray_post: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (hit == '0) && (busy == '0)) |=> (busy == '0));

  // R5: the alarm word changes only on its apply cycle
  a_r5_alarm_only_on_apply: assert property (@(posedge clk) disable iff (rst)
    !apply[CH_ALM] |=> (alm_q == $past(alm_q)));

endmodule

// File: tb/rtc_cal_top_tb_top.sv
`timescale 1ns/1ps
module rtc_cal_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  always #2.5 clk = ~clk;

  rtc_cal_top #(.ADDR_W(8), .APPLY_DELAY(3)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_YMD = 8'h10, A_HMS = 8'h14, A_ALM = 8'h18;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench time model
  int ms, mm, mh, md, mmo, my, mlp;

  function automatic int dim(int mo, int lp);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] pk_hms(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] pk_ymd(int lp, int y, int mo, int d);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  task automatic model_tick();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0; md++;
      if (md > dim(mmo, mlp)) begin
        md = 1; mmo++;
        if (mmo == 13) begin mmo = 1; my = (my + 1) % 64; end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    step();
    d = bus_rdata;
  endtask

  task automatic tk();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  task automatic set_all(int h, int m, int s, int lp, int y, int mo, int d);
    wr(A_HMS, pk_hms(h, m, s));
    wr(A_YMD, pk_ymd(lp, y, mo, d));
    settle();
    mh = h; mm = m; ms = s; mlp = lp; my = y; mmo = mo; md = d;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] keep;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset values
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_HMS, v);  chk("R1 hms", v, 32'h0);
    rd(A_YMD, v);  chk("R1 ymd", v, 32'h00000101);
    rd(A_ALM, v);  chk("R1 alm", v, 32'h0);

    // R5 flag timing: set for three reads, clear on the fourth
    wr(A_HMS, pk_hms(5, 6, 7));
    rd(A_CTRL, v); chk("R5 busy read1", v, 32'h100);
    rd(A_CTRL, v); chk("R5 busy read2", v, 32'h100);
    rd(A_CTRL, v); chk("R5 busy read3", v, 32'h100);
    rd(A_CTRL, v); chk("R5 busy clear", v, 32'h0);
    rd(A_HMS, v);  chk("R5 hms applied", v, pk_hms(5, 6, 7));

    // R5 old value visible until the third edge
    wr(A_HMS, pk_hms(10, 20, 30));
    rd(A_HMS, v); chk("R5 old1", v, pk_hms(5, 6, 7));
    rd(A_HMS, v); chk("R5 old2", v, pk_hms(5, 6, 7));
    rd(A_HMS, v); chk("R5 old3", v, pk_hms(5, 6, 7));
    rd(A_HMS, v); chk("R5 new", v, pk_hms(10, 20, 30));

    // R5 alarm path uses flag bit 9
    wr(A_ALM, (32'd17 << 24) | pk_hms(6, 30, 0));
    rd(A_CTRL, v); chk("R5 alarm busy", v, 32'h200);
    settle();
    rd(A_ALM, v); chk("R5 alarm value", v, (32'd17 << 24) | pk_hms(6, 30, 0));

    // R6 write while busy is dropped
    wr(A_HMS, pk_hms(1, 2, 3));
    wr(A_HMS, pk_hms(9, 9, 9));
    settle();
    rd(A_HMS, v);  chk("R6 first write kept", v, pk_hms(1, 2, 3));
    rd(A_CTRL, v); chk("R6 no restart", v, 32'h0);

    // R8 both pending, date untouched by time write
    rd(A_YMD, keep);
    wr(A_HMS, pk_hms(4, 4, 4));
    rd(A_CTRL, v); chk("R8 only time busy", v, 32'h100);
    settle();
    rd(A_YMD, v); chk("R8 date untouched", v, keep);
    wr(A_HMS, pk_hms(3, 3, 3));
    wr(A_YMD, pk_ymd(0, 10, 7, 4));
    rd(A_CTRL, v); chk("R8 both busy", v, 32'h180);
    settle();
    rd(A_HMS, v); chk("R8 time", v, pk_hms(3, 3, 3));
    rd(A_YMD, v); chk("R8 date", v, pk_ymd(0, 10, 7, 4));

    // R9 control and unmapped writes ignored
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R9 ctrl write", v, 32'h0);
    wr(8'h40, 32'h1234_5678);
    rd(8'h40, v); chk("R9 unmapped read", v, 32'h0);
    rd(A_CTRL, v); chk("R9 unmapped no busy", v, 32'h0);
    rd(A_HMS, v); chk("R9 time kept", v, pk_hms(3, 3, 3));

    // R10 junk bits dropped
    wr(A_HMS, pk_hms(12, 34, 56) | 32'hFFE0_C0C0);
    wr(A_YMD, pk_ymd(1, 20, 2, 14) | 32'hFF80_F0E0);
    wr(A_ALM, (32'd31 << 24) | pk_hms(23, 59, 58) | 32'hE080_C0C0);
    settle();
    rd(A_HMS, v); chk("R10 hms", v, pk_hms(12, 34, 56));
    rd(A_YMD, v); chk("R10 ymd", v, pk_ymd(1, 20, 2, 14));
    rd(A_ALM, v); chk("R10 alm", v, (32'd31 << 24) | pk_hms(23, 59, 58));

    // R7 tick on time apply cycle: written value wins
    wr(A_HMS, pk_hms(8, 0, 0));
    step(); step();
    tk();
    rd(A_HMS, v); chk("R7 time wins", v, pk_hms(8, 0, 0));
    rd(A_YMD, v); chk("R7 date not advanced", v, pk_ymd(1, 20, 2, 14));
    // R7 tick on date apply cycle: tick dropped for time too
    set_all(23, 59, 59, 0, 30, 5, 31);
    wr(A_YMD, pk_ymd(0, 30, 6, 1));
    step(); step();
    tk();
    rd(A_YMD, v); chk("R7 date wins", v, pk_ymd(0, 30, 6, 1));
    rd(A_HMS, v); chk("R7 time held", v, pk_hms(23, 59, 59));

    // R3 last day of every month, both leap settings
    for (int mo = 1; mo <= 12; mo++) begin
      for (int lp = 0; lp < 2; lp++) begin
        set_all(23, 59, 59, lp, 5, mo, dim(mo, lp));
        tk(); model_tick();
        rd(A_YMD, v); chk($sformatf("R3 month %0d leap %0d", mo, lp), v, pk_ymd(mlp, my, mmo, md));
        rd(A_HMS, v); chk("R3 midnight", v, pk_hms(0, 0, 0));
      end
    end
    // R3 Feb 28 with leap goes to Feb 29
    set_all(23, 59, 59, 1, 2, 2, 28);
    tk();
    rd(A_YMD, v); chk("R3 feb29", v, pk_ymd(1, 2, 2, 29));
    // R3 year wrap 63 -> 0
    set_all(23, 59, 59, 0, 63, 12, 31);
    tk();
    rd(A_YMD, v); chk("R3 year wrap", v, pk_ymd(0, 0, 1, 1));

    // R2 long run across second, minute, hour and day carries
    set_all(22, 58, 30, 0, 44, 3, 9);
    for (int i = 0; i < 3700; i++) begin
      tk(); model_tick();
      rd(A_HMS, v);
      chk("R2 time sweep", v, pk_hms(mh, mm, ms));
    end
    rd(A_YMD, v); chk("R2 day carry", v, pk_ymd(0, 44, 3, 10));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule